// File: doc/BRIEF.md
# Port Pin Interrupt Detector

This block watches the sixteen input pins of one general-purpose port and turns pin activity into interrupt requests. Each pin is set to edge or level detection and has two enables: one for a rising edge or high level, one for a falling edge or low level. Pins in edge mode can run through a de-bounce filter. Every detection sets a sticky per-pin status flag, and a single interrupt line reports that at least one flag is set.

Software reaches the block through a small word-wide register port with a two-bit address. The four registers are trigger type, enables, de-bounce enables and status. Status flags are cleared by writing ones to them. A synthesis parameter sets how many pins the port really has. Pins above that count never raise a flag.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset every register reads zero and `irqOut` is low, so every pin starts in edge mode with both enables off.
- R2: The trigger-type register is at address 0. Bit n = 1 selects level mode for pin n and 0 selects edge mode. Only bits [15:0] are stored, and bits [31:16] read as zero.
- R3: The enable register is at address 1. Bit n+16 enables rising edge or high level for pin n, and bit n enables falling edge or low level. In edge mode with the rising enable set, a 0-to-1 transition sets status bit n.
- R4: In edge mode with the falling enable set, a 1-to-0 transition sets the flag. With both enables set, either transition sets it.
- R5: In level mode, a pin sitting at its single enabled level sets its flag. The flag sets again on the next cycle after a clear while that level persists.
- R6: In level mode, a pin with both enables set never sets its flag.
- R7: The de-bounce enable register is at address 2, bit n for pin n. For an edge-mode pin with de-bounce on, a new level is accepted only after two consecutive equal samples taken on a divided sample tick, so a one-cycle glitch raises no flag.
- R8: For a level-mode pin the de-bounce enable has no effect: the flag sets with the same latency as without de-bounce.
- R9: The status register is at address 3. Flags are sticky. Writing 1 to bit n clears flag n, and writing 0 leaves it. A detection in the same cycle as its clear wins, so the flag stays set.
- R10: `irqOut` is high exactly when any status flag is set.
- R11: Pins numbered `NUM_PINS` and above never set a status flag, whatever the configuration.
- R12: A pin change driven before a clock edge appears in the status register after the third rising clock edge: two synchroniser stages, then the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset, synchronous |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select for reads and writes |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data of the selected register, combinational |
| pinIn | input | 16 | Raw port pin levels |
| irqOut | output | 1 | Combined interrupt request |

## Verification
A write-one-to-clear of a status flag can land in the same cycle as a fresh detection on that pin. The bench provokes this by holding a level-mode pin at its active level while it writes all ones to the status register. It then reads the flag back in the next cycle and expects it still set. Only once the pin has gone inactive does a further clear leave the flag at zero.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int PORT_W = 16;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 32;

  typedef enum logic [ADDR_W-1:0] {
    REG_TYPE     = 2'd0,
    REG_ENABLE   = 2'd1,
    REG_DEBOUNCE = 2'd2,
    REG_STATUS   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic wrType;
    logic wrEnable;
    logic wrDebounce;
    logic clrStatus;
    logic sampleTick;
  } ctrl_strobe_t;
endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int TICK_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrl_strobe_t      strb
);
  localparam int CNT_W = $clog2(TICK_DIV + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_DIV - 1);

  logic [CNT_W-1:0] tickCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (tickCnt == CNT_LAST) begin
      tickCnt <= '0;
    end else begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  always_comb begin
    strb.wrType     = regWrEn && (regAddr == REG_TYPE);
    strb.wrEnable   = regWrEn && (regAddr == REG_ENABLE);
    strb.wrDebounce = regWrEn && (regAddr == REG_DEBOUNCE);
    strb.clrStatus  = regWrEn && (regAddr == REG_STATUS);
    strb.sampleTick = (tickCnt == CNT_LAST);
  end

  // R9
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrType, strb.wrEnable, strb.wrDebounce, strb.clrStatus}));

  generate
    if (TICK_DIV > 1) begin : g_tickChk
      // R7
      tick_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
        strb.sampleTick |=> !strb.sampleTick);
    end
  endgenerate
endmodule

// File: rtl/gpio_irq_dpath.sv
module gpio_irq_dpath
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [PORT_W-1:0] pinIn,
  output logic              irqOut
);
  localparam logic [PORT_W-1:0] IMPL_MASK = PORT_W'((32'd1 << NUM_PINS) - 1);

  logic [PORT_W-1:0] trigLevel, riseEn, fallEn, debEn, status;
  logic [PORT_W-1:0] syncA, syncB, debVal, srcPrev;
  logic [PORT_W-1:0] srcVal, setMask, clrMask;

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      trigLevel <= '0;
      riseEn    <= '0;
      fallEn    <= '0;
      debEn     <= '0;
    end else begin
      if (strb.wrType)     trigLevel <= regWrData[PORT_W-1:0];
      if (strb.wrEnable)   {riseEn, fallEn} <= regWrData;
      if (strb.wrDebounce) debEn <= regWrData[PORT_W-1:0];
    end
  end

  // two-stage input synchroniser
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
    end
  end

  // per-pin filter and detection; unimplemented pins are tied off
  generate
    for (genvar p = 0; p < PORT_W; p++) begin : g_pin
      if (p < NUM_PINS) begin : g_live
        logic lastSample;
        logic useDeb;
        logic levelHit, edgeHit;

        always_ff @(posedge clk) begin
          if (!rstN) begin
            lastSample <= 1'b0;
            debVal     <= '0;
          end else if (strb.sampleTick) begin
            lastSample <= syncB[p];
            if (syncB[p] == lastSample) debVal[p] <= syncB[p];
          end
        end

        always_ff @(posedge clk) begin
          if (!rstN) srcPrev[p] <= 1'b0;
          else       srcPrev[p] <= srcVal[p];
        end

        always_comb begin
          useDeb    = debEn[p] & ~trigLevel[p];
          srcVal[p] = useDeb ? debVal[p] : syncB[p];
          edgeHit   = ~trigLevel[p] &
                      ((riseEn[p] & srcVal[p] & ~srcPrev[p]) |
                       (fallEn[p] & ~srcVal[p] & srcPrev[p]));
          levelHit  = trigLevel[p] & (riseEn[p] ^ fallEn[p]) &
                      ((riseEn[p] & syncB[p]) | (fallEn[p] & ~syncB[p]));
          setMask[p] = edgeHit | levelHit;
        end
      end else begin : g_dead
        always_ff @(posedge clk) begin
          debVal[p]  <= 1'b0;
          srcPrev[p] <= 1'b0;
        end
        assign srcVal[p]  = 1'b0;
        assign setMask[p] = 1'b0;
      end
    end
  endgenerate

  // sticky status, write-one-to-clear, detection wins
  assign clrMask = strb.clrStatus ? regWrData[PORT_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) status <= '0;
    else       status <= (status & ~clrMask) | setMask;
  end

  assign irqOut = |status;

  always_comb begin
    unique case (reg_sel_e'(regAddr))
      REG_TYPE:     regRdData = {16'h0, trigLevel};
      REG_ENABLE:   regRdData = {riseEn, fallEn};
      REG_DEBOUNCE: regRdData = {16'h0, debEn};
      REG_STATUS:   regRdData = {16'h0, status};
      default:      regRdData = '0;
    endcase
  end

  // R11
  unimpl_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (status & ~IMPL_MASK) == '0);

  // R6
  invalid_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((status & ~$past(status)) & $past(trigLevel & riseEn & fallEn)) == '0);

  // R9
  sticky_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    (($past(status) & ~status) & ~$past(clrMask)) == '0);

  // R7
  deb_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.sampleTick |=> $stable(debVal));

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == REG_TYPE) |-> (regRdData[31:16] == 16'h0));

  // R10
  irq_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == REG_STATUS && regRdData != '0) |-> irqOut);
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int TICK_DIV = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic [15:0] pinIn,
  output logic        irqOut
);
  ctrl_strobe_t strb;

  gpio_irq_ctrl #(.TICK_DIV(TICK_DIV)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strb    (strb)
  );

  gpio_irq_dpath #(.NUM_PINS(NUM_PINS)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .pinIn     (pinIn),
    .irqOut    (irqOut)
  );
endmodule

// File: tb/gpio_irq_detect_bench.sv
module gpio_irq_detect_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 7;

  // {mode, enable{rise,fall}, pinsBefore, pinsAfter, expectedStatus}
  localparam logic [95:0] VEC [N_VEC] = '{
    {16'h0000, 32'h00FF_0000, 16'h0000, 16'h0F0F, 16'h000F}, // R3 rising
    {16'h0000, 32'h0000_FFFF, 16'h00FF, 16'h0F0F, 16'h00F0}, // R4 falling
    {16'h0000, 32'h0F00_0F00, 16'h0300, 16'h0C00, 16'h0F00}, // R4 both edges
    {16'hFFFF, 32'h00F0_000F, 16'h0000, 16'h0000, 16'h000F}, // R5 low level
    {16'hFFFF, 32'h00FF_00F0, 16'h00FF, 16'h00FF, 16'h000F}, // R6 invalid 4..7
    {16'h00FF, 32'hFFFF_0000, 16'h0000, 16'hFFFF, 16'h7FFF}, // R5 mix, R11
    {16'h0000, 32'hFFFF_FFFF, 16'h8000, 16'h0000, 16'h0000}  // R11 pin 15
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [15:0] pinIn = '0;
  logic        irqOut;

  int nChecks = 0;
  int nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_detect #(.NUM_PINS(15), .TICK_DIV(4)) u_gpio_irq_detect (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .pinIn(pinIn), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    @(negedge clk); cycles(3);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rdReg(a[1:0], rd);
      check("R1", rd, 32'h0);
    end
    check("R1", {31'h0, irqOut}, 32'h0);

    // R2 reserved bits of the type register
    wrReg(2'd0, 32'hFFFF_FFFF);
    rdReg(2'd0, rd);
    check("R2", rd, 32'h0000_FFFF);

    // vector table
    for (int v = 0; v < N_VEC; v++) begin
      wrReg(2'd0, {16'h0, VEC[v][95:80]});
      wrReg(2'd1, VEC[v][79:48]);
      wrReg(2'd2, 32'h0);
      pinIn = VEC[v][47:32];
      cycles(6);
      wrReg(2'd3, 32'h0000_FFFF);
      pinIn = VEC[v][31:16];
      cycles(6);
      rdReg(2'd3, rd);
      check($sformatf("R3-table vector %0d", v), rd, {16'h0, VEC[v][15:0]});
    end

    // R12 latency of an edge detection
    pinIn = '0;
    wrReg(2'd0, 32'h0);
    wrReg(2'd1, 32'h0001_0000);
    cycles(5);
    wrReg(2'd3, 32'hFFFF);
    pinIn[0] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rdReg(2'd3, rd);
    check("R12 before third edge", rd, 32'h0);
    @(posedge clk); @(negedge clk);
    rdReg(2'd3, rd);
    check("R12 after third edge", rd, 32'h1);

    // R9 partial clear, R10 interrupt line
    wrReg(2'd1, 32'h000F_0000);
    wrReg(2'd3, 32'hFFFF);
    pinIn = 16'h000F;
    cycles(5);
    wrReg(2'd3, 32'h0000_0003);
    rdReg(2'd3, rd);
    check("R9 partial clear", rd, 32'h000C);
    check("R10 irq set", {31'h0, irqOut}, 32'h1);
    wrReg(2'd3, 32'h0000_000C);
    rdReg(2'd3, rd);
    check("R9 full clear", rd, 32'h0);
    check("R10 irq clear", {31'h0, irqOut}, 32'h0);

    // R7 de-bounce rejects a glitch, accepts a held level
    pinIn = '0;
    wrReg(2'd1, 32'h0002_0000);
    wrReg(2'd2, 32'h0002);
    cycles(20);
    wrReg(2'd3, 32'hFFFF);
    pinIn[1] = 1'b1;
    @(negedge clk);
    pinIn[1] = 1'b0;
    cycles(30);
    rdReg(2'd3, rd);
    check("R7 glitch rejected", rd, 32'h0);
    pinIn[1] = 1'b1;
    cycles(30);
    rdReg(2'd3, rd);
    check("R7 held level accepted", rd, 32'h0002);

    // R8 de-bounce ignored in level mode
    pinIn = '0;
    wrReg(2'd0, 32'h0004);
    wrReg(2'd1, 32'h0004_0000);
    wrReg(2'd2, 32'h0004);
    cycles(5);
    wrReg(2'd3, 32'hFFFF);
    pinIn[2] = 1'b1;
    @(posedge clk); @(posedge clk); @(posedge clk); @(negedge clk);
    rdReg(2'd3, rd);
    check("R8 level latency with de-bounce on", rd, 32'h0004);

    // R5 and R9: clear while level still active, detection wins
    wrReg(2'd3, 32'hFFFF);
    rdReg(2'd3, rd);
    check("R9 set wins over clear", rd, 32'h0004);
    pinIn[2] = 1'b0;
    cycles(4);
    wrReg(2'd3, 32'hFFFF);
    rdReg(2'd3, rd);
    check("R5 clear after level gone", rd, 32'h0);

    // R6 directed: both enables in level mode never fire
    wrReg(2'd1, 32'h0004_0004);
    pinIn[2] = 1'b1;
    cycles(6);
    pinIn[2] = 1'b0;
    cycles(6);
    rdReg(2'd3, rd);
    check("R6 invalid level setting", rd, 32'h0);

    finishRun();
  end
endmodule